// File: doc/BRIEF.md
# Local Port Frame and Clock Timing Generator

This block produces the timing for the local side of a serial time-slot switch. From a 32.768 MHz system clock it makes three local clocks (4.096, 8.192 and 16.384 MHz) and three 8 kHz frame pulses. The pulses are 8, 4 and 2 system clocks wide, one for each clock domain. Each pulse is centred on the local frame boundary. At that boundary all three clocks have a falling edge at the same instant.

The local frame follows the backplane frame by a fixed delay. The backplane timing logic gives a one-cycle strobe at each backplane frame boundary and a rate-mode bit. A strobe starts a countdown. When the countdown ends, the internal frame position is re-phased so that the local boundary lands exactly on the required delay. If strobes stop arriving, the generator keeps running with a frame of 4096 system clocks. Static configuration inputs choose the active level of each frame pulse and can invert the 8.192 MHz clock. These inputs act only at the output registers.

Top module: `local_port_timing`

## Requirements
- R1: With `rate_sel`=0 (16 Mb/s backplane), the local boundary is seen at the ports 72 system clocks after the clock edge that samples `bp_fbound` high. That is 18 periods of the 8.192 MHz clock: two 16 Mb/s channels plus ten periods.
- R2: With `rate_sel`=1 (32 Mb/s backplane), the same delay is 56 system clocks (14 periods of the 8.192 MHz clock). The rate is taken at the strobe.
- R3: `lclk16_o`, `lclk8_o` and `lclk4_o` have periods of 2, 4 and 8 system clocks. Let p be the frame position, where p=0 is the first cycle after the boundary. Then the clocks are p[0], p[1] and p[2]. All three fall together at the boundary.
- R4: The 4.096 MHz-domain pulse `lfp4_o` is active for 8 cycles: positions 4092..4095 and 0..3.
- R5: `lfp8_o` is active at positions 4094, 4095, 0 and 1. `lfp16_o` is active at positions 4095 and 0.
- R6: The local boundary is the falling edge of the uninverted 8.192 MHz clock that occurs while `lfp8_o` is active.
- R7: Each pulse has its own polarity input (`pol_fp4`, `pol_fp8`, `pol_fp16`). A 1 makes the pulse active high and a 0 makes it active low. The new setting shows from the next cycle, and pulse timing does not change.
- R8: `inv_c8`=1 inverts `lclk8_o` from the next cycle. The other clocks are not affected.
- R9: With no strobe, the frame repeats every 4096 system clocks.
- R10: While `rst` is high, all clocks are low, `lclk8_o` equals `inv_c8`, and each pulse sits at its inactive level.
- R11: A strobe that arrives while a countdown is pending restarts the countdown. The boundary then follows the latest strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_fbound | input | 1 | One-cycle backplane frame-boundary strobe |
| rate_sel | input | 1 | Backplane rate: 0 = 16 Mb/s, 1 = 32 Mb/s |
| pol_fp4 | input | 1 | `lfp4_o` active level |
| pol_fp8 | input | 1 | `lfp8_o` active level |
| pol_fp16 | input | 1 | `lfp16_o` active level |
| inv_c8 | input | 1 | Invert `lclk8_o` |
| lclk4_o | output | 1 | 4.096 MHz local clock |
| lclk8_o | output | 1 | 8.192 MHz local clock |
| lclk16_o | output | 1 | 16.384 MHz local clock |
| lfp4_o | output | 1 | 8-cycle frame pulse |
| lfp8_o | output | 1 | 4-cycle frame pulse |
| lfp16_o | output | 1 | 2-cycle frame pulse |

## Verification
Every output is a direct function of one frame position. A wrong position therefore shows up at all six pins within one cycle of the error. It appears as a clock phase slip, a pulse that is shifted, or a pulse with the wrong width. A wrong countdown load or a wrong re-phase moves the boundary away from cycle 72 or 56 after the strobe. Loss of wrap or free-running shows at the next expected boundary, 4096 cycles later. The bench tracks the expected position arithmetically on every cycle of these windows, so a single-cycle slip is caught where it happens.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic {RATE_16 = 1'b0, RATE_32 = 1'b1} rate_e;

  // Delay in system clocks: channels * c8 periods per channel + extra c8 periods.
  function automatic int delay_sys(input int chans, input int c8_per_chan,
                                   input int extra_c8, input int sys_per_c8);
    return (chans * c8_per_chan + extra_c8) * sys_per_c8;
  endfunction
endpackage

// File: rtl/lpt_boundary_delay.sv
module lpt_boundary_delay #(
  parameter int DLY_16 = 72,
  parameter int DLY_32 = 56,
  parameter int LEAD   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic rate,
  output logic rephase
);
  // Re-phase fires LEAD cycles before the frame position reaches zero;
  // two further cycles are spent in the frame counter and output stage.
  localparam int LD16 = DLY_16 - 2 - LEAD;
  localparam int LD32 = DLY_32 - 2 - LEAD;
  localparam int LMAX = (LD16 > LD32) ? LD16 : LD32;
  localparam int CW   = $clog2(LMAX + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strobe) begin
      busy <= 1'b1;
      cnt  <= rate ? CW'(LD32) : CW'(LD16);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign rephase = busy && (cnt == '0) && !strobe;
endmodule

// File: rtl/lpt_frame_counter.sv
module lpt_frame_counter #(
  parameter int FRAME_LEN = 4096,
  parameter int LEAD      = 4,
  localparam int PW       = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rephase,
  output logic [PW-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)                               pos <= '0;
    else if (rephase)                      pos <= PW'(FRAME_LEN - LEAD);
    else if (pos == PW'(FRAME_LEN - 1))    pos <= '0;
    else                                   pos <= pos + 1'b1;
  end
endmodule

// File: rtl/lpt_output_stage.sv
module lpt_output_stage #(
  parameter int FRAME_LEN = 4096,
  localparam int PW       = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic [2:0]    pol,      // [0]=4 MHz pulse, [1]=8 MHz, [2]=16 MHz
  input  logic          inv_c8,
  output logic          c4_o,
  output logic          c8_o,
  output logic          c16_o,
  output logic [2:0]    fp_o,
  output logic          c8_raw,
  output logic          fp8_act
);
  // Half-widths in system clocks of the 4, 8 and 16 MHz domain pulses.
  localparam int HALF [3] = '{4, 2, 1};

  logic [2:0] act_q;
  logic       c4r, c16r;

  for (genvar i = 0; i < 3; i++) begin : g_pulse
    logic win;
    assign win = (int'(pos) >= FRAME_LEN - HALF[i]) || (int'(pos) < HALF[i]);
    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[i] <= 1'b0;
        fp_o[i]  <= ~pol[i];
      end else begin
        act_q[i] <= win;
        fp_o[i]  <= win ? pol[i] : ~pol[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c4r <= 1'b0; c8_raw <= 1'b0; c16r <= 1'b0;
      c4_o <= 1'b0; c8_o <= inv_c8; c16_o <= 1'b0;
    end else begin
      c16r   <= pos[0];
      c8_raw <= pos[1];
      c4r    <= pos[2];
      c16_o  <= pos[0];
      c8_o   <= pos[1] ^ inv_c8;
      c4_o   <= pos[2];
    end
  end

  assign fp8_act = act_q[1];

  assert_nest16_R5: assert property (@(posedge clk) disable iff (rst)
    act_q[2] |-> act_q[1]);
  assert_nest8_R4: assert property (@(posedge clk) disable iff (rst)
    act_q[1] |-> act_q[0]);
  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(c8_raw) && act_q[1]) |-> ($fell(c4r) && $fell(c16r)));
endmodule

// File: rtl/local_port_timing.sv
module local_port_timing #(
  parameter int FRAME_LEN   = 4096,
  parameter int SYS_PER_C8  = 4,
  parameter int C8_PER_CH16 = 4,
  parameter int C8_PER_CH32 = 2,
  parameter int DELAY_CH    = 2,
  parameter int EXTRA_C8    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bp_fbound,
  input  logic rate_sel,
  input  logic pol_fp4,
  input  logic pol_fp8,
  input  logic pol_fp16,
  input  logic inv_c8,
  output logic lclk4_o,
  output logic lclk8_o,
  output logic lclk16_o,
  output logic lfp4_o,
  output logic lfp8_o,
  output logic lfp16_o
);
  import lpt_pkg::*;

  localparam int PW     = $clog2(FRAME_LEN);
  localparam int LEAD   = 4;
  localparam int DLY_16 = delay_sys(DELAY_CH, C8_PER_CH16, EXTRA_C8, SYS_PER_C8);
  localparam int DLY_32 = delay_sys(DELAY_CH, C8_PER_CH32, EXTRA_C8, SYS_PER_C8);

  logic          rephase;
  logic [PW-1:0] pos;
  logic [2:0]    fp;
  logic          c8_raw, fp8_act;

  lpt_boundary_delay #(.DLY_16(DLY_16), .DLY_32(DLY_32), .LEAD(LEAD)) u_dly (
    .clk(clk), .rst(rst), .strobe(bp_fbound), .rate(rate_sel), .rephase(rephase));

  lpt_frame_counter #(.FRAME_LEN(FRAME_LEN), .LEAD(LEAD)) u_cnt (
    .clk(clk), .rst(rst), .rephase(rephase), .pos(pos));

  lpt_output_stage #(.FRAME_LEN(FRAME_LEN)) u_out (
    .clk(clk), .rst(rst), .pos(pos), .pol({pol_fp16, pol_fp8, pol_fp4}),
    .inv_c8(inv_c8), .c4_o(lclk4_o), .c8_o(lclk8_o), .c16_o(lclk16_o),
    .fp_o(fp), .c8_raw(c8_raw), .fp8_act(fp8_act));

  assign lfp4_o  = fp[0];
  assign lfp8_o  = fp[1];
  assign lfp16_o = fp[2];

  // Checker: cycles since the latest strobe, and the rate latched with it.
  localparam int SW = PW + 1;
  logic [SW-1:0] chk_since;
  logic          chk_valid;
  rate_e         chk_mode;
  logic          bnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_since <= '0;
      chk_valid <= 1'b0;
      chk_mode  <= RATE_16;
    end else if (bp_fbound) begin
      chk_since <= '0;
      chk_valid <= 1'b1;
      chk_mode  <= rate_e'(rate_sel);
    end else if (chk_since != '1) begin
      chk_since <= chk_since + 1'b1;
    end
  end

  assign bnd = fp8_act && !c8_raw;

  assert_delay16_R1: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_mode == RATE_16 && chk_since == SW'(DLY_16)) |-> ($fell(c8_raw) && bnd));
  assert_delay32_R2: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_mode == RATE_32 && chk_since == SW'(DLY_32)) |-> ($fell(c8_raw) && bnd));
endmodule

// File: tb/tb_local_port_timing.sv
module tb_local_port_timing;
  localparam int FRAME = 4096;
  localparam int D16   = (2 * 4 + 10) * 4;   // R1
  localparam int D32   = (2 * 2 + 10) * 4;   // R2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bp_fbound = 1'b0, rate_sel = 1'b0;
  logic pol_fp4 = 1'b0, pol_fp8 = 1'b0, pol_fp16 = 1'b0, inv_c8 = 1'b0;
  logic lclk4_o, lclk8_o, lclk16_o, lfp4_o, lfp8_o, lfp16_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  local_port_timing dut (
    .clk(clk), .rst(rst), .bp_fbound(bp_fbound), .rate_sel(rate_sel),
    .pol_fp4(pol_fp4), .pol_fp8(pol_fp8), .pol_fp16(pol_fp16), .inv_c8(inv_c8),
    .lclk4_o(lclk4_o), .lclk8_o(lclk8_o), .lclk16_o(lclk16_o),
    .lfp4_o(lfp4_o), .lfp8_o(lfp8_o), .lfp16_o(lfp16_o));

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit in_win(input int p, input int half);
    return (p >= FRAME - half) || (p < half);
  endfunction

  task automatic strobe(input logic rate);
    @(negedge clk);
    bp_fbound = 1'b1;
    rate_sel  = rate;
    @(posedge clk);
    @(negedge clk);
    bp_fbound = 1'b0;
  endtask

  // Tracks cycles m after the strobe edge; checks every port from m = d-4.
  task automatic track(input int d, input int n, input bit sweep, input string dtag);
    logic prev_c8raw = 1'b0;
    for (int m = 1; m <= n; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m >= d - 4) begin
        int p = (((m - d) % FRAME) + FRAME) % FRAME;
        logic raw8 = lclk8_o ^ inv_c8;
        string ptag = sweep ? "R7" : "R5";
        chk(lclk16_o, p[0], "R3", "lclk16_o");
        chk(lclk4_o,  p[2], "R3", "lclk4_o");
        chk(lclk8_o,  p[1] ^ inv_c8, inv_c8 ? "R8" : "R3", "lclk8_o");
        chk(lfp4_o,  in_win(p, 4) ? pol_fp4  : ~pol_fp4,  sweep ? "R7" : "R4", "lfp4_o");
        chk(lfp8_o,  in_win(p, 2) ? pol_fp8  : ~pol_fp8,  ptag, "lfp8_o");
        chk(lfp16_o, in_win(p, 1) ? pol_fp16 : ~pol_fp16, ptag, "lfp16_o");
        if (m == d) begin
          chk(lfp8_o == pol_fp8 && !raw8 && prev_c8raw, 1'b1, dtag, "boundary at delay");
          chk(lfp8_o == pol_fp8 && !raw8, 1'b1, "R6", "c8 fall inside fp8");
        end
        if (m == d + FRAME)
          chk(lfp8_o == pol_fp8 && !raw8 && prev_c8raw, 1'b1, "R9", "free-run boundary");
        prev_c8raw = raw8;
      end
      if (sweep) begin
        {pol_fp4, pol_fp8, pol_fp16, inv_c8} = 4'(m * 7);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lclk4_o,  1'b0, "R10", "reset lclk4_o");
    chk(lclk8_o,  1'b0, "R10", "reset lclk8_o");
    chk(lclk16_o, 1'b0, "R10", "reset lclk16_o");
    chk(lfp4_o,   1'b1, "R10", "reset lfp4_o");
    chk(lfp8_o,   1'b1, "R10", "reset lfp8_o");
    chk(lfp16_o,  1'b1, "R10", "reset lfp16_o");
    rst = 1'b0;
    repeat (37) @(posedge clk);

    // R1 and R9: 16 Mb/s mode, active-high pulses, over a full free-run frame.
    pol_fp4 = 1'b1; pol_fp8 = 1'b1; pol_fp16 = 1'b1; inv_c8 = 1'b0;
    strobe(1'b0);
    track(D16, D16 + FRAME + 8, 1'b0, "R1");

    // R2 with a polarity / invert sweep (R7, R8).
    pol_fp4 = 1'b0; pol_fp8 = 1'b1; pol_fp16 = 1'b0; inv_c8 = 1'b1;
    repeat (13) @(posedge clk);
    strobe(1'b1);
    track(D32, D32 + 300, 1'b1, "R2");

    // R11: second strobe during a pending countdown restarts it.
    pol_fp4 = 1'b1; pol_fp8 = 1'b0; pol_fp16 = 1'b1; inv_c8 = 1'b0;
    strobe(1'b0);
    repeat (21) @(negedge clk);
    strobe(1'b0);
    track(D16, D16 + 200, 1'b0, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule